// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a sixteen-entry VLAN membership table for an eight-port switch in flip-flops. A host reaches it through a plain 32-bit register port. The host places the membership and egress-tag words in two staging registers. It then writes the command register with the go bit set and a command code: a write copies the staging words into the chosen entry, and a read copies the entry back into the staging words. A busy flag in the command register stays high for a fixed number of cycles while the operation runs. The operation takes effect on the cycle the flag drops.

Next to the table there is a small packed VID memory. Each 32-bit word holds the 12-bit VIDs of two neighbouring entries. The host reads and writes these words directly, and commands do not touch them.

Register offsets: command 0x090, staging word A 0x094, staging word B 0x098, and VID words from 0x100 to 0x11C.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, the command register, both staging words and all VID words read as zero. The busy bit (command bit 31) reads 0.
- R2: A write to offset 0x090 with bit 31 set, while idle, starts an operation. Bit 31 then reads 1 for exactly BUSY_CYCLES (default 4) cycles and then 0. A write with bit 31 clear starts nothing.
- R3: While busy, host writes to offsets 0x090, 0x094 and 0x098 are ignored. The running command, its index and the staging words stay unchanged.
- R4: Command code 1 in bits 15:12 writes an entry. The entry index is taken from bits 3:0. The entry takes these fields from staging word A: valid flag in bit 0, 8-bit port member mask in bits 23:16, tag enable in bit 28 and independent learning in bit 30. It takes the 16-bit egress field from bits 15:0 of staging word B.
- R5: Command code 0 reads an entry. Staging word A is loaded with the stored fields at the bit positions of R4, with all other bits zero. Staging word B is loaded with the 16-bit egress field, with bits 31:16 zero.
- R6: A read of an entry whose valid flag is 0 loads zero into both staging words.
- R7: A write command with staging word A all zeros invalidates the entry. A later read then returns zero in both staging words, even if staging word B was not zero.
- R8: Each port n has a 2-bit egress code in bits 2n+1:2n of staging word B: 0 untag, 1 swap, 2 tag, 3 stack. All four codes are stored and read back per port without change.
- R9: A command code other than 0 or 1 keeps the busy timing of R2 but changes neither the table nor the staging words.
- R10: VID word k (0 to 7) is at offset 0x100+4k. Entry i uses word i/2: bits 11:0 for an even i and bits 23:12 for an odd i. A word write stores both VIDs, and bits 31:24 read as zero.
- R11: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.
- R12: Command register bits 15:12 and 3:0 read back the code and index of the last accepted command. Ignored writes do not alter them.
- R13: The staging words read back the exact 32-bit value last written by the host, until a read command replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situation to reach is a host write that lands inside the busy window: a second command, or a new staging value, sent while an operation is still running. The bench starts a write command and then issues a staging write and a competing command on the very next clock edges. After the operation ends, it shows that the first index and data were committed, that the competing entry is still invalid, and that the recorded command did not change. A second case is an unknown command code with staging words already loaded. Reading the entry back afterwards shows that the table kept its earlier contents.

// File: rtl/vlan_tbl_pkg.sv
// Package: shared sizes, register offsets, field positions and entry type
// for the VLAN table command engine. Assumes the port count fits the
// 8-bit member field of staging word A.
package vlan_tbl_pkg;
    parameter int unsigned VT_PORTS   = 8;
    parameter int unsigned VT_ENTRIES = 16;
    parameter int unsigned VT_VID_W   = 12;
    parameter int unsigned VT_BUSY    = 4;
    parameter int unsigned VT_DATA_W  = 32;
    parameter int unsigned VT_ADDR_W  = 12;

    localparam logic [VT_ADDR_W-1:0] VT_OFF_CMD  = 12'h090;
    localparam logic [VT_ADDR_W-1:0] VT_OFF_STA  = 12'h094;
    localparam logic [VT_ADDR_W-1:0] VT_OFF_STB  = 12'h098;
    localparam logic [VT_ADDR_W-1:0] VT_VID_BASE = 12'h100;

    localparam int unsigned VT_GO_BIT    = 31;
    localparam int unsigned VT_CODE_LSB  = 12;
    localparam int unsigned VT_VALID_BIT = 0;
    localparam int unsigned VT_MEMB_LSB  = 16;
    localparam int unsigned VT_TAG_BIT   = 28;
    localparam int unsigned VT_IVL_BIT   = 30;

    localparam logic [3:0] VT_OPC_READ  = 4'd0;
    localparam logic [3:0] VT_OPC_WRITE = 4'd1;

    typedef enum logic [1:0] {
        EG_UNTAG = 2'd0,
        EG_SWAP  = 2'd1,
        EG_TAG   = 2'd2,
        EG_STACK = 2'd3
    } vt_egress_e;

    typedef struct packed {
        logic                    ivl;
        logic                    tag_en;
        logic [VT_PORTS-1:0]     members;
        logic                    valid;
        logic [2*VT_PORTS-1:0]   egress;
    } vt_entry_t;
endpackage

// File: rtl/vlan_op_sequencer.sv
// Module: accepts a command when idle, holds busy for BUSY_CYCLES cycles
// and pulses done on the last busy cycle. Assumes BUSY_CYCLES >= 1.
module vlan_op_sequencer #(
    parameter int unsigned BUSY_CYCLES = 4,
    parameter int unsigned IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic             go_i,
    input  logic [3:0]       code_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [3:0]       code_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       code_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;

    assign accept = cmd_wr_i && go_i && !busy_q;

    // Start, count down and finish an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            code_q <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            code_q <= code_i;
            idx_q  <= idx_i;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);
    assign code_o = code_q;
    assign idx_o  = idx_q;

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && go_i && !busy_o) |=> (busy_o && cnt_q == CNT_LOAD));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cnt_q) == '0));

    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_wr_i) |=> ($stable(code_o) && $stable(idx_o)));
endmodule

// File: rtl/vlan_entry_array.sv
// Module: register array of VLAN entries with one write port and one
// combinational read port. Assumes index values below ENTRIES.
module vlan_entry_array
    import vlan_tbl_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  vt_entry_t        wr_entry_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output vt_entry_t        rd_entry_o
);
    vt_entry_t tbl_q [ENTRIES];

    // Clear on reset; store one entry on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < int'(ENTRIES); e++) begin
                tbl_q[e] <= '0;
            end
        end else if (wr_en_i) begin
            tbl_q[wr_idx_i] <= wr_entry_i;
        end
    end

    // Read mux for the selected entry.
    assign rd_entry_o = tbl_q[rd_idx_i];

    assert_entry_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (tbl_q[$past(wr_idx_i)] == $past(wr_entry_i)));
endmodule

// File: rtl/vlan_vid_words.sv
// Module: packed VID memory, two VIDs per word, host word access only.
// Assumes an even entry count.
module vlan_vid_words #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned VID_W = 12,
    parameter int unsigned WW    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [WW-1:0]      wr_word_i,
    input  logic [2*VID_W-1:0] wr_data_i,
    input  logic [WW-1:0]      rd_word_i,
    output logic [2*VID_W-1:0] rd_data_o
);
    logic [2*VID_W-1:0] word_q [WORDS];

    // Clear on reset; store a whole word pair on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < int'(WORDS); w++) begin
                word_q[w] <= '0;
            end
        end else if (wr_en_i) begin
            word_q[wr_word_i] <= wr_data_i;
        end
    end

    // Word read mux.
    assign rd_data_o = word_q[rd_word_i];

    assert_vid_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (word_q[$past(wr_word_i)] == $past(wr_data_i)));
endmodule

// File: rtl/vlan_cmd_engine.sv
// Module: top of the VLAN table command engine. Decodes the register port,
// holds the staging words and joins sequencer, entry array and VID words.
// Assumes single-cycle write strobes and combinational reads.
module vlan_cmd_engine
    import vlan_tbl_pkg::*;
#(
    parameter int unsigned ENTRIES     = VT_ENTRIES,
    parameter int unsigned BUSY_CYCLES = VT_BUSY
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wen,
    input  logic [VT_ADDR_W-1:0] bus_addr,
    input  logic [VT_DATA_W-1:0] bus_wdata,
    output logic [VT_DATA_W-1:0] bus_rdata
);
    localparam int unsigned IDX_W     = $clog2(ENTRIES);
    localparam int unsigned VID_WORDS = ENTRIES / 2;
    localparam int unsigned VW_W      = (VID_WORDS > 1) ? $clog2(VID_WORDS) : 1;
    localparam logic [VT_ADDR_W-1:0] VID_END = VT_VID_BASE + VT_ADDR_W'(4 * VID_WORDS);

    logic                 hit_cmd, hit_sta, hit_stb, hit_vid;
    logic [VT_ADDR_W-1:0] vid_off;
    logic [VW_W-1:0]      vid_word;
    logic                 busy, done;
    logic [3:0]           op_code;
    logic [IDX_W-1:0]     op_idx;
    logic [VT_DATA_W-1:0] sta_q, stb_q;
    vt_entry_t            wr_entry, rd_entry;
    logic                 rd_done, wr_done;
    logic [2*VT_VID_W-1:0] vid_rd;
    logic [VT_DATA_W-1:0] sta_load, stb_load, cmd_view;

    // Address decode for every mapped register.
    always_comb begin
        hit_cmd  = (bus_addr == VT_OFF_CMD);
        hit_sta  = (bus_addr == VT_OFF_STA);
        hit_stb  = (bus_addr == VT_OFF_STB);
        hit_vid  = (bus_addr >= VT_VID_BASE) && (bus_addr < VID_END) && (bus_addr[1:0] == 2'b00);
        vid_off  = bus_addr - VT_VID_BASE;
        vid_word = vid_off[VW_W+1:2];
    end

    vlan_op_sequencer #(.BUSY_CYCLES(BUSY_CYCLES), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr_i (bus_wen && hit_cmd),
        .go_i     (bus_wdata[VT_GO_BIT]),
        .code_i   (bus_wdata[VT_CODE_LSB +: 4]),
        .idx_i    (bus_wdata[IDX_W-1:0]),
        .busy_o   (busy),
        .done_o   (done),
        .code_o   (op_code),
        .idx_o    (op_idx)
    );

    assign rd_done = done && (op_code == VT_OPC_READ);
    assign wr_done = done && (op_code == VT_OPC_WRITE);

    // Unpack staging words into an entry for a write command.
    always_comb begin
        wr_entry.valid   = sta_q[VT_VALID_BIT];
        wr_entry.members = sta_q[VT_MEMB_LSB +: VT_PORTS];
        wr_entry.tag_en  = sta_q[VT_TAG_BIT];
        wr_entry.ivl     = sta_q[VT_IVL_BIT];
        wr_entry.egress  = stb_q[2*VT_PORTS-1:0];
    end

    vlan_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_done),
        .wr_idx_i   (op_idx),
        .wr_entry_i (wr_entry),
        .rd_idx_i   (op_idx),
        .rd_entry_o (rd_entry)
    );

    vlan_vid_words #(.WORDS(VID_WORDS), .VID_W(VT_VID_W), .WW(VW_W)) u_vid (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (bus_wen && hit_vid),
        .wr_word_i (vid_word),
        .wr_data_i (bus_wdata[2*VT_VID_W-1:0]),
        .rd_word_i (vid_word),
        .rd_data_o (vid_rd)
    );

    // Pack a stored entry into staging images; invalid entries give zero.
    always_comb begin
        sta_load = '0;
        stb_load = '0;
        if (rd_entry.valid) begin
            sta_load[VT_VALID_BIT]             = 1'b1;
            sta_load[VT_MEMB_LSB +: VT_PORTS]  = rd_entry.members;
            sta_load[VT_TAG_BIT]               = rd_entry.tag_en;
            sta_load[VT_IVL_BIT]               = rd_entry.ivl;
            stb_load[2*VT_PORTS-1:0]           = rd_entry.egress;
        end
    end

    // Staging words: loaded by a read command or by an idle host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= '0;
            stb_q <= '0;
        end else if (rd_done) begin
            sta_q <= sta_load;
            stb_q <= stb_load;
        end else if (bus_wen && !busy) begin
            if (hit_sta) sta_q <= bus_wdata;
            if (hit_stb) stb_q <= bus_wdata;
        end
    end

    // Command register view: busy, last code, last index.
    always_comb begin
        cmd_view                    = '0;
        cmd_view[VT_GO_BIT]         = busy;
        cmd_view[VT_CODE_LSB +: 4]  = op_code;
        cmd_view[IDX_W-1:0]         = op_idx;
    end

    // Read data mux; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_cmd)      bus_rdata = cmd_view;
        else if (hit_sta) bus_rdata = sta_q;
        else if (hit_stb) bus_rdata = stb_q;
        else if (hit_vid) bus_rdata[2*VT_VID_W-1:0] = vid_rd;
    end

    assert_invalid_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_entry.valid) |=> (sta_q == '0 && stb_q == '0));

    assert_stage_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(sta_q) && $stable(stb_q)));

    assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_code != VT_OPC_READ) |=> ($stable(sta_q) && $stable(stb_q)));
endmodule

// File: tb/vlan_cmd_engine_test.sv
// Directed bench for vlan_cmd_engine: one task per scenario.
module vlan_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wen = 1'b0;
    logic [11:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    localparam int BUSY = 4;

    always #5 clk = ~clk;

    vlan_cmd_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (b_wen),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (b_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        b_addr = a; b_wdata = d; b_wen = 1'b1;
        @(negedge clk);
        b_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        b_addr = a;
        #1;
        d = b_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            bus_read(12'h090, v);
            if (!v[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [3:0] code, input logic [3:0] idx);
        bus_write(12'h090, 32'h8000_0000 | (32'(code) << 12) | 32'(idx));
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(12'h090, v); check("R1 cmd", v, 0);
        bus_read(12'h094, v); check("R1 stage A", v, 0);
        bus_read(12'h098, v); check("R1 stage B", v, 0);
        bus_read(12'h100, v); check("R1 vid0", v, 0);
        bus_read(12'h11C, v); check("R1 vid7", v, 0);
    endtask

    task automatic t_busy_timing();
        logic [31:0] v;
        int cnt = 0;
        bus_write(12'h090, 32'h0000_1002);
        bus_read(12'h090, v); check("R2 no go bit", {31'd0, v[31]}, 0);
        check("R12 no go keeps record", v, 0);
        bus_write(12'h090, 32'h8000_0002);
        for (int i = 0; i < 20; i++) begin
            bus_read(12'h090, v);
            if (!v[31]) break;
            cnt++;
            @(negedge clk);
        end
        check("R2 busy cycles", 32'(cnt), 32'(BUSY));
    endtask

    task automatic t_write_read();
        logic [31:0] v;
        bus_write(12'h094, 32'h5A5A_5A5B);
        bus_write(12'h098, 32'h1234_5678);
        bus_read(12'h094, v); check("R13 stage A readback", v, 32'h5A5A_5A5B);
        run_cmd(4'd1, 4'd4);
        bus_write(12'h094, 32'h0);
        bus_write(12'h098, 32'h0);
        run_cmd(4'd0, 4'd4);
        bus_read(12'h094, v); check("R4 R5 stage A fields", v, 32'h505A_0001);
        bus_read(12'h098, v); check("R5 stage B egress", v, 32'h0000_5678);
    endtask

    task automatic t_invalidate();
        logic [31:0] v;
        bus_write(12'h094, 32'h0);
        bus_write(12'h098, 32'hFFFF_FFFF);
        run_cmd(4'd1, 4'd4);
        bus_write(12'h094, 32'h1234_1234);
        run_cmd(4'd0, 4'd4);
        bus_read(12'h094, v); check("R7 invalidated A", v, 0);
        bus_read(12'h098, v); check("R7 invalidated B", v, 0);
    endtask

    task automatic t_invalid_read();
        logic [31:0] v;
        bus_write(12'h094, 32'hDEAD_BEEF);
        bus_write(12'h098, 32'hDEAD_BEEF);
        run_cmd(4'd0, 4'd9);
        bus_read(12'h094, v); check("R6 never written A", v, 0);
        bus_read(12'h098, v); check("R6 never written B", v, 0);
    endtask

    task automatic t_egress_codes();
        logic [31:0] v;
        bus_write(12'h094, 32'h00FF_0001);
        bus_write(12'h098, 32'h0000_E4E4); // ports 0..3: untag, swap, tag, stack, repeated
        run_cmd(4'd1, 4'd15);
        bus_write(12'h098, 32'h0);
        run_cmd(4'd0, 4'd15);
        bus_read(12'h098, v); check("R8 egress codes", v, 32'h0000_E4E4);
        bus_read(12'h090, v); check("R12 last command", v, 32'h0000_000F);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        bus_write(12'h094, 32'h00FF_0001);
        bus_write(12'h098, 32'h0000_AAAA);
        bus_write(12'h090, 32'h8000_1003);
        bus_write(12'h094, 32'h0000_0000);
        bus_write(12'h090, 32'h8000_1005);
        wait_idle();
        bus_read(12'h090, v); check("R3 R12 command kept", v, 32'h0000_1003);
        bus_read(12'h094, v); check("R3 stage A kept", v, 32'h00FF_0001);
        run_cmd(4'd0, 4'd5);
        bus_read(12'h094, v); check("R3 entry 5 untouched", v, 0);
    endtask

    task automatic t_bad_code();
        logic [31:0] v;
        int cnt = 0;
        bus_write(12'h094, 32'h1111_1111);
        bus_write(12'h098, 32'h0000_2222);
        bus_write(12'h090, 32'h8000_2003);
        for (int i = 0; i < 20; i++) begin
            bus_read(12'h090, v);
            if (!v[31]) break;
            cnt++;
            @(negedge clk);
        end
        check("R9 busy cycles", 32'(cnt), 32'(BUSY));
        bus_read(12'h090, v); check("R12 code 2 recorded", v, 32'h0000_2003);
        bus_read(12'h094, v); check("R9 stage A unchanged", v, 32'h1111_1111);
        run_cmd(4'd0, 4'd3);
        bus_read(12'h094, v); check("R9 entry A unchanged", v, 32'h00FF_0001);
        bus_read(12'h098, v); check("R9 entry B unchanged", v, 32'h0000_AAAA);
    endtask

    task automatic t_vid_mem();
        logic [31:0] v;
        bus_write(12'h104, 32'hFFAB_C123);
        bus_write(12'h11C, 32'h0076_5FFF);
        bus_read(12'h104, v);
        check("R10 word readback", v, 32'h00AB_C123);
        check("R10 even index 2", {20'd0, v[11:0]}, 32'h123);
        check("R10 odd index 3", {20'd0, v[23:12]}, 32'hABC);
        bus_read(12'h11C, v); check("R10 word 7", v, 32'h0076_5FFF);
        bus_read(12'h100, v); check("R10 word 0 untouched", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(12'h094, 32'h0F0F_0F0F);
        bus_write(12'h0A0, 32'hFFFF_FFFF);
        bus_write(12'h120, 32'hFFFF_FFFF);
        bus_read(12'h0A0, v); check("R11 unmapped 0A0", v, 0);
        bus_read(12'h120, v); check("R11 unmapped 120", v, 0);
        bus_read(12'h094, v); check("R11 stage A untouched", v, 32'h0F0F_0F0F);
        bus_read(12'h104, v); check("R11 vid untouched", v, 32'h00AB_C123);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_timing();
        t_write_read();
        t_invalidate();
        t_invalid_read();
        t_egress_codes();
        t_busy_ignore();
        t_bad_code();
        t_vid_mem();
        t_unmapped();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule